// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is one channel of a bus-master DMA engine that moves 16-bit words between a drive's data port and 32-bit system memory. It takes its work from a table of descriptors in memory. Each descriptor is two 32-bit words: a buffer start address, then a byte count in the low half with an end-of-table flag in the top bit. The engine reads a descriptor, moves one 16-bit word per memory access until that descriptor's count is used up, and then reads the next descriptor. After the descriptor flagged as the last one is finished, it stops.

The register block supplies a level `go`, a direction bit, a table-pointer load and a one-cycle `restart` pulse. `restart` is pulsed when software sets the start command. The drive supplies its DMA request `dreq`. Work goes forward only while both `go` and `dreq` are high. When either drops the engine pauses, and it resumes from the same place. Every memory access is a request that is held until `mem_rdy` is seen high in the same cycle. A 16-bit word sits on the upper or lower half of the 32-bit data bus, selected by bit 1 of its byte address.

Top module: `sg_dma_engine`

## Requirements
- R1: `mem_req` is high only in cycles where `go` and `dreq` are both high. While either is low the engine holds its position, and the next request after they return is the one that was pending.
- R2: After reset `active`, `done`, `mem_req`, `dev_rd` and `dev_wr` are all low. A `restart` pulse clears the remaining count and the end-of-table flag, and sets `active` high and `done` low from the next cycle. The next access is then a descriptor read at the table pointer.
- R3: A descriptor is fetched as two full-word reads (`mem_be` = 1111, `mem_we` = 0), first at the table pointer and then at pointer+4. The following descriptor is read at pointer+8. No device strobe accompanies a fetch.
- R4: The buffer address is the first descriptor word with bit 0 forced to 0. The byte count is bits 15:0 of the second word with bit 0 forced to 0. The end-of-table flag is bit 31 of the second word.
- R5: A data access uses `mem_addr` equal to the buffer address with bits 1:0 cleared. If buffer address bit 1 is 1, the word uses data bits 31:16 and `mem_be` = 1100. Otherwise it uses bits 15:0 and `mem_be` = 0011.
- R6: With `dir_to_mem` = 1, each data access is a memory write of `dev_rdata` placed on the selected half. `dev_rd` pulses in the cycle that write is accepted.
- R7: With `dir_to_mem` = 0, each data access is a memory read. `dev_wr` pulses in the accepting cycle, with `dev_wdata` equal to the selected half of `mem_rdata`.
- R8: Each accepted data access adds 2 to the buffer address and subtracts 2 from the count. When the count reaches zero and the flag is clear, the next access is the next descriptor fetch.
- R9: When the count reaches zero with the end-of-table flag set, `done` goes high and `active` goes low. No further memory request is made until the next `restart`.
- R10: A descriptor count field of zero means 65536 bytes, which is 32768 word transfers.
- R11: A table-pointer load stores `tbl_ptr_in` with bits 1:0 forced to 0.
- R12: An unaccepted request keeps `mem_addr` and `mem_be` unchanged into the next cycle, unless it is withdrawn by R1 or the pointer is reloaded. A held write also keeps its `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | Start command level from the register block |
| dir_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| restart | input | 1 | One-cycle pulse on the start command's rising edge |
| tbl_ptr_load | input | 1 | Load strobe for the descriptor table pointer |
| tbl_ptr_in | input | BUS_W | New table pointer value |
| dreq | input | 1 | DMA request from the drive |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | BUS_W | Dword-aligned memory address |
| mem_be | output | BUS_W/8 | Memory byte enables |
| mem_wdata | output | BUS_W | Memory write data |
| mem_rdata | input | BUS_W | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory accepts the access this cycle |
| dev_rd | output | 1 | Device data-port read strobe |
| dev_wr | output | 1 | Device data-port write strobe |
| dev_rdata | input | WORD_W | Data word presented by the device |
| dev_wdata | output | WORD_W | Data word sent to the device |
| active | output | 1 | Engine is walking the table |
| done | output | 1 | End of table reached |

## Verification
The bench builds the block at its default parameters: a 32-bit bus, 16-bit words and a 16-bit count field. At these values both halves of a data word are reachable, and so is the 65536-byte meaning of a zero count, which takes 32768 word transfers. The bench runs a descriptor whose count field is zero to the end and counts its device strobes. Short odd-addressed and odd-count descriptors, a memory with irregular ready timing, and pauses on both `go` and `dreq` cover lane selection, request holding and resumption.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic [2:0] {
    SG_IDLE   = 3'd0,
    SG_FETCH0 = 3'd1,
    SG_FETCH1 = 3'd2,
    SG_XFER   = 3'd3,
    SG_DONE   = 3'd4
  } sg_state_e;

  function automatic logic is_fetch(input sg_state_e s);
    return (s == SG_FETCH0) || (s == SG_FETCH1);
  endfunction

  function automatic logic is_busy(input sg_state_e s);
    return (s == SG_FETCH0) || (s == SG_FETCH1) || (s == SG_XFER);
  endfunction

endpackage

// File: rtl/sgdma_rst_sync.sv
module sgdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      run_ok,
  input  logic      mem_rdy,
  input  logic      last_word,
  input  logic      eot,
  output sg_state_e state,
  output logic      issue,
  output logic      accept
);
  sg_state_e state_q, state_d;

  // a request is offered only while the channel may move; restart withdraws it
  assign issue  = is_busy(state_q) && run_ok && !restart;
  assign accept = issue && mem_rdy;

  always_comb begin
    state_d = state_q;
    if (restart) begin
      state_d = SG_FETCH0;
    end else if (accept) begin
      case (state_q)
        SG_FETCH0: state_d = SG_FETCH1;
        SG_FETCH1: state_d = SG_XFER;
        SG_XFER: begin
          if (last_word) state_d = eot ? SG_DONE : SG_FETCH0;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SG_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sgdma_desc.sv
module sgdma_desc
  import sgdma_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ptr_load,
  input  logic [BUS_W-1:0] ptr_in,
  input  sg_state_e        state,
  input  logic             accept,
  input  logic [BUS_W-1:0] rdata,
  input  logic [CNT_W-1:0] cnt_field,
  input  logic             eot_field,
  output logic [BUS_W-1:0] ptr,
  output logic [BUS_W-1:0] cur_addr,
  output logic             eot,
  output logic             last_word
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BUS_BYTES  = BUS_W / 8;
  localparam logic [BUS_W-1:0] PTR_MASK  = ~BUS_W'(BUS_BYTES - 1);
  localparam logic [BUS_W-1:0] ADDR_MASK = ~BUS_W'(WORD_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_MASK  = ~CNT_W'(WORD_BYTES - 1);
  localparam logic [CNT_W:0]   CNT_STEP  = (CNT_W+1)'(WORD_BYTES);
  localparam logic [CNT_W:0]   CNT_FULL  = (CNT_W+1)'(1) << CNT_W;

  logic [BUS_W-1:0] ptr_q, ptr_d;
  logic [BUS_W-1:0] addr_q, addr_d;
  logic [CNT_W:0]   cnt_q, cnt_d;
  logic             eot_q, eot_d;
  logic [CNT_W-1:0] cnt_even;
  logic             ptr_en, walk_en;

  assign cnt_even = cnt_field & CNT_MASK;
  assign ptr_en   = ptr_load || (accept && is_fetch(state));
  assign walk_en  = restart || accept;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load) ptr_d = ptr_in & PTR_MASK;
    else          ptr_d = ptr_q + BUS_W'(BUS_BYTES);
  end

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    eot_d  = eot_q;
    if (restart) begin
      cnt_d = '0;
      eot_d = 1'b0;
    end else begin
      case (state)
        SG_FETCH0: addr_d = rdata & ADDR_MASK;
        SG_FETCH1: begin
          cnt_d = (cnt_even == '0) ? CNT_FULL : {1'b0, cnt_even};
          eot_d = eot_field;
        end
        SG_XFER: begin
          addr_d = addr_q + BUS_W'(WORD_BYTES);
          cnt_d  = cnt_q - CNT_STEP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      eot_q  <= 1'b0;
    end else if (walk_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      eot_q  <= eot_d;
    end
  end

  assign ptr       = ptr_q;
  assign cur_addr  = addr_q;
  assign eot       = eot_q;
  assign last_word = (cnt_q == CNT_STEP);
endmodule

// File: rtl/sgdma_lane.sv
module sgdma_lane #(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic [((BUS_W/WORD_W) > 1 ? $clog2(BUS_W/WORD_W) : 1)-1:0] sel,
  input  logic [WORD_W-1:0] dev_word,
  input  logic [BUS_W-1:0]  rdata,
  output logic [BUS_W-1:0]  wdata,
  output logic [BUS_W/8-1:0] be,
  output logic [WORD_W-1:0] dev_out
);
  localparam int HALVES     = BUS_W / WORD_W;
  localparam int SEL_W      = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam int WORD_BYTES = WORD_W / 8;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic hit;
    assign hit = (sel == SEL_W'(h));
    assign wdata[h*WORD_W +: WORD_W]  = hit ? dev_word : '0;
    assign be[h*WORD_BYTES +: WORD_BYTES] = {WORD_BYTES{hit}};
  end

  always_comb begin
    dev_out = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (sel == SEL_W'(h)) dev_out = rdata[h*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sgdma_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 dir_to_mem,
  input  logic                 restart,
  input  logic                 tbl_ptr_load,
  input  logic [BUS_W-1:0]     tbl_ptr_in,
  input  logic                 dreq,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [BUS_W-1:0]     mem_addr,
  output logic [BUS_W/8-1:0]   mem_be,
  output logic [BUS_W-1:0]     mem_wdata,
  input  logic [BUS_W-1:0]     mem_rdata,
  input  logic                 mem_rdy,
  output logic                 dev_rd,
  output logic                 dev_wr,
  input  logic [WORD_W-1:0]    dev_rdata,
  output logic [WORD_W-1:0]    dev_wdata,
  output logic                 active,
  output logic                 done
);
  localparam int BE_W   = BUS_W / 8;
  localparam int HALVES = BUS_W / WORD_W;
  localparam int SEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam int SEL_LO = $clog2(WORD_W / 8);
  localparam logic [BUS_W-1:0] DW_MASK = ~BUS_W'(BE_W - 1);

  logic             rst_sync_n;
  sg_state_e        state;
  logic             issue, accept;
  logic [BUS_W-1:0] ptr, cur_addr;
  logic             eot, last_word;
  logic             xfer;
  logic [SEL_W-1:0] lane_sel;
  logic [BUS_W-1:0] lane_wdata;
  logic [BE_W-1:0]  lane_be;
  logic [WORD_W-1:0] lane_dev;

  sgdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sgdma_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .restart   (restart),
    .run_ok    (go && dreq),
    .mem_rdy   (mem_rdy),
    .last_word (last_word),
    .eot       (eot),
    .state     (state),
    .issue     (issue),
    .accept    (accept)
  );

  sgdma_desc #(
    .BUS_W  (BUS_W),
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_desc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .restart   (restart),
    .ptr_load  (tbl_ptr_load),
    .ptr_in    (tbl_ptr_in),
    .state     (state),
    .accept    (accept),
    .rdata     (mem_rdata),
    .cnt_field (mem_rdata[CNT_W-1:0]),
    .eot_field (mem_rdata[BUS_W-1]),
    .ptr       (ptr),
    .cur_addr  (cur_addr),
    .eot       (eot),
    .last_word (last_word)
  );

  assign lane_sel = cur_addr[SEL_LO +: SEL_W];

  sgdma_lane #(
    .BUS_W  (BUS_W),
    .WORD_W (WORD_W)
  ) u_lane (
    .sel      (lane_sel),
    .dev_word (dev_rdata),
    .rdata    (mem_rdata),
    .wdata    (lane_wdata),
    .be       (lane_be),
    .dev_out  (lane_dev)
  );

  assign xfer      = (state == SG_XFER);
  assign mem_req   = issue;
  assign mem_we    = xfer && dir_to_mem;
  assign mem_addr  = xfer ? (cur_addr & DW_MASK) : ptr;
  assign mem_be    = xfer ? lane_be : '1;
  assign mem_wdata = lane_wdata;
  assign dev_wdata = lane_dev;
  assign dev_rd    = accept && xfer && dir_to_mem;
  assign dev_wr    = accept && xfer && !dir_to_mem;
  assign active    = is_busy(state);
  assign done      = (state == SG_DONE);
endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker #(
  parameter int BUS_W  = 32,
  parameter int WORD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               go,
  input logic               dreq,
  input logic               restart,
  input logic               tbl_ptr_load,
  input logic               mem_req,
  input logic               mem_rdy,
  input logic               mem_we,
  input logic [BUS_W-1:0]   mem_addr,
  input logic [BUS_W/8-1:0] mem_be,
  input logic [BUS_W-1:0]   mem_wdata,
  input logic               dev_rd,
  input logic               dev_wr,
  input logic               active,
  input logic               done
);
  localparam logic [BUS_W-1:0] LOW_BITS = BUS_W'(BUS_W/8 - 1);

  assert_req_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (go && dreq && !restart));

  assert_restart_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (active && !done));

  assert_addr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & LOW_BITS) == '0));

  assert_write_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == WORD_W/8));

  assert_rd_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |-> (mem_req && mem_rdy && mem_we && !dev_wr));

  assert_wr_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> (mem_req && mem_rdy && !mem_we && !dev_rd));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_req && !active));

  assert_done_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);

  assert_hold_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy && !tbl_ptr_load) |=>
      (!mem_req || ($stable(mem_addr) && $stable(mem_be) &&
                    (!(mem_we && $past(mem_we)) || $stable(mem_wdata)))));
endmodule

bind sg_dma_engine sgdma_checker #(
  .BUS_W  (BUS_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .go           (go),
  .dreq         (dreq),
  .restart      (restart),
  .tbl_ptr_load (tbl_ptr_load),
  .mem_req      (mem_req),
  .mem_rdy      (mem_rdy),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .mem_wdata    (mem_wdata),
  .dev_rd       (dev_rd),
  .dev_wr       (dev_wr),
  .active       (active),
  .done         (done)
);

// File: tb/sg_dma_engine_tb_top.sv
module sg_dma_engine_tb_top;
  localparam int BUS_W  = 32;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, go, dir_to_mem, restart, tbl_ptr_load, dreq, mem_rdy;
  logic [31:0] tbl_ptr_in, mem_rdata, mem_addr, mem_wdata;
  logic        mem_req, mem_we, dev_rd, dev_wr, active, done;
  logic [3:0]  mem_be;
  logic [15:0] dev_rdata, dev_wdata;

  sg_dma_engine #(.BUS_W(BUS_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .dir_to_mem(dir_to_mem),
    .restart(restart), .tbl_ptr_load(tbl_ptr_load), .tbl_ptr_in(tbl_ptr_in),
    .dreq(dreq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .active(active), .done(done)
  );

  // bench memory: 4 KiB, writes at or above 0x1000 are dropped
  logic [31:0] bmem [0:1023];
  assign mem_rdata = bmem[mem_addr[11:2]];

  // reference model: expected access stream
  logic [31:0] q_addr[$];
  logic [3:0]  q_be[$];
  logic        q_we[$];
  logic [31:0] q_data[$];
  bit          q_fetch[$];
  string       q_tag[$];

  int checks = 0, fails = 0;
  int exp_dev_idx = 0, dev_idx = 0;
  int dev_rd_cnt = 0, dev_wr_cnt = 0, cyc = 0, rdy_mode = 0;
  bit dev_consume = 0, mon_en = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic push(input logic [31:0] a, input logic [3:0] be, input logic we,
                      input logic [31:0] d, input bit f, input string tag);
    q_addr.push_back(a); q_be.push_back(be); q_we.push_back(we);
    q_data.push_back(d); q_fetch.push_back(f); q_tag.push_back(tag);
  endtask

  task automatic flush_model();
    q_addr.delete(); q_be.delete(); q_we.delete();
    q_data.delete(); q_fetch.delete(); q_tag.delete();
  endtask

  // walk the descriptor table as the requirements describe it
  task automatic build_walk(input logic [31:0] ptr_raw, input bit dir);
    logic [31:0] p, w0, w1, a, wd;
    int n;
    bit last;
    logic [15:0] dv;
    p = ptr_raw & ~32'h3;
    last = 0;
    for (int d = 0; d < 16 && !last; d++) begin
      w0 = bmem[p[11:2]];
      w1 = bmem[p[11:2] + 10'd1];
      push(p, 4'hF, 1'b0, 32'h0, 1, "R3 R11");
      push(p + 32'd4, 4'hF, 1'b0, 32'h0, 1, "R3");
      p = p + 32'd8;
      a = w0 & ~32'h1;
      n = int'(w1[15:0] & 16'hFFFE);
      if (n == 0) n = 65536;
      for (int i = 0; i < n / 2; i++) begin
        if (dir) begin
          dv = 16'hA000 + 16'(exp_dev_idx);
          exp_dev_idx++;
          wd = a[1] ? {dv, 16'h0} : {16'h0, dv};
        end else begin
          wd = a[1] ? {16'h0, bmem[a[11:2]][31:16]} : {16'h0, bmem[a[11:2]][15:0]};
        end
        push(a & ~32'h3, a[1] ? 4'b1100 : 4'b0011, dir, wd, 0, "R4 R5 R8 R10");
        a = a + 32'd2;
      end
      last = w1[31];
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (mem_req) begin
        chk(go && dreq, "R1", "request without go and dreq", {30'h0, go, dreq}, 32'h3);
        if (q_addr.size() == 0) begin
          chk(0, "R9", "request after end of table", mem_addr, 32'h0);
        end else begin
          chk(mem_addr == q_addr[0], q_tag[0], "address", mem_addr, q_addr[0]);
          chk(mem_be == q_be[0] && mem_we == q_we[0], q_tag[0], "enables/we",
              {27'h0, mem_we, mem_be}, {27'h0, q_we[0], q_be[0]});
          if (mem_we)
            chk((mem_wdata & be_mask(mem_be)) == q_data[0], "R6", "write data",
                mem_wdata & be_mask(mem_be), q_data[0]);
          if (mem_rdy) begin
            if (q_fetch[0]) begin
              chk(!dev_rd && !dev_wr, "R3", "strobe on fetch", {30'h0, dev_rd, dev_wr}, 32'h0);
            end else if (q_we[0]) begin
              chk(dev_rd && !dev_wr, "R6", "read strobe", {30'h0, dev_rd, dev_wr}, 32'h2);
            end else begin
              chk(dev_wr && !dev_rd, "R7", "write strobe", {30'h0, dev_rd, dev_wr}, 32'h1);
              chk(dev_wdata == q_data[0][15:0], "R7", "device word",
                  {16'h0, dev_wdata}, q_data[0]);
            end
            if (mem_we && mem_addr < 32'h1000) begin
              for (int b = 0; b < 4; b++)
                if (mem_be[b]) bmem[mem_addr[11:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end
            if (dev_rd) begin dev_rd_cnt++; dev_consume = 1; end
            if (dev_wr) dev_wr_cnt++;
            void'(q_addr.pop_front()); void'(q_be.pop_front()); void'(q_we.pop_front());
            void'(q_data.pop_front()); void'(q_fetch.pop_front()); void'(q_tag.pop_front());
          end
        end
      end else begin
        chk(!dev_rd && !dev_wr, "R6 R7", "strobe without access", {30'h0, dev_rd, dev_wr}, 32'h0);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
    cyc++;
    if (dev_consume) begin
      dev_idx++;
      dev_rdata = 16'hA000 + 16'(dev_idx);
      dev_consume = 0;
    end
    mem_rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  endtask

  task automatic start_walk(input logic [31:0] ptr, input bit dir);
    flush_model();
    build_walk(ptr, dir);
    tbl_ptr_in = ptr; tbl_ptr_load = 1; restart = 1; dir_to_mem = dir;
    tick();
    tbl_ptr_load = 0; restart = 0;
    chk(active == 1'b1 && done == 1'b0, "R2", "active after restart",
        {30'h0, active, done}, 32'h2);
  endtask

  task automatic drain(input int lim);
    for (int i = 0; i < lim && q_addr.size() != 0; i++) tick();
    chk(q_addr.size() == 0, "R8", "accesses left in model", q_addr.size(), 0);
    tick(); tick();
    chk(done == 1'b1 && active == 1'b0, "R9", "done after last descriptor",
        {30'h0, active, done}, 32'h1);
  endtask

  initial begin
    int rd0, wr0;
    rst_n = 0; go = 0; dir_to_mem = 0; restart = 0; tbl_ptr_load = 0;
    tbl_ptr_in = 0; dreq = 0; mem_rdy = 1; dev_rdata = 16'hA000;
    for (int i = 0; i < 1024; i++) bmem[i] = 32'h0;
    // tables and data
    bmem[64] = 32'h0000_0203; bmem[65] = 32'h0000_0007;
    bmem[66] = 32'h0000_0300; bmem[67] = 32'h8000_0004;
    bmem[96] = 32'h0000_0400; bmem[97] = 32'h0000_0004;
    bmem[98] = 32'h0000_040A; bmem[99] = 32'h8000_0002;
    bmem[112] = 32'h0001_0000; bmem[113] = 32'h8000_0000;
    bmem[128] = 32'h1111_2222; bmem[129] = 32'h3333_4444;
    bmem[192] = 32'h5555_6666;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    chk(!mem_req && !active && !done && !dev_rd && !dev_wr, "R2", "reset state",
        {27'h0, mem_req, active, done, dev_rd, dev_wr}, 32'h0);
    mon_en = 1;

    // memory to device, odd pointer and odd buffer address, irregular ready, pauses
    rdy_mode = 1; go = 1; dreq = 1;
    start_walk(32'h0000_0103, 0);
    repeat (3) tick();
    dreq = 0;
    repeat (5) begin tick(); chk(!mem_req, "R1", "request while dreq low", mem_req, 0); end
    dreq = 1; go = 0;
    repeat (4) begin tick(); chk(!mem_req, "R1", "request while go low", mem_req, 0); end
    go = 1;
    drain(200);
    chk(dev_wr_cnt == 5, "R7", "device writes", dev_wr_cnt, 5);
    repeat (10) tick();
    chk(done && !mem_req, "R9", "idle after end of table", {30'h0, done, mem_req}, 32'h2);

    // device to memory, lane placement
    rdy_mode = 0;
    start_walk(32'h0000_0180, 1);
    drain(200);
    chk(bmem[256] == 32'hA001_A000, "R6", "written dword 0x400", bmem[256], 32'hA001_A000);
    chk(bmem[258][31:16] == 16'hA002, "R5", "upper half at 0x40A",
        {16'h0, bmem[258][31:16]}, 32'h0000_A002);

    // restart in the middle of a walk
    rdy_mode = 1;
    start_walk(32'h0000_0100, 0);
    repeat (6) tick();
    start_walk(32'h0000_0180, 0);
    drain(200);

    // zero count field means 65536 bytes
    rdy_mode = 0; rd0 = dev_rd_cnt; wr0 = dev_wr_cnt;
    start_walk(32'h0000_01C0, 1);
    drain(40000);
    chk(dev_rd_cnt - rd0 == 32768, "R10", "words for zero count", dev_rd_cnt - rd0, 32768);
    chk(dev_wr_cnt == wr0, "R6", "no device writes in device-to-memory run", dev_wr_cnt, wr0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule